// File: doc/BRIEF.md
# Load Data Byte-Order and Width Shaper

This block sits between the memory read port and the register-file write port of a load unit. It takes one raw 64-bit word as read from memory, together with the size of the access, and turns it into the value to be written into a destination element. Three steps run in sequence. The bytes of the access are optionally reversed. The access is widened into an intermediate wider than any element. That intermediate is then either cut or clamped to the destination element size.

Whether bytes are reversed depends on two inputs. One is the byte-reverse flavour of the load instruction. The other is the endianness the machine currently runs in. The two are folded into a single decision, so one reversal network serves both. Saturation works on the widened intermediate, so out-of-range values clamp correctly instead of wrapping.

The block is one register stage. A request presented with `in_valid` produces its result on `out_data` one clock later, flagged by `out_valid`.

Top module: `load_shaper`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first request, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` equals `in_valid` of the previous clock. The result of a request appears on `out_data` in the cycle after it is presented. `out_data` holds its value while no request is presented.
- R3: Bytes are reversed exactly when `in_rev` equals `in_le` (XNOR). When they differ, bytes keep their order.
- R4: Reversal affects only the bytes of the access, never the full word. With access size n bytes, result byte k (k < n) is raw byte n-1-k.
- R5: Raw bits at and above the access size are ignored.
- R6: Size codes for `in_opw` and `in_dstw` are 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64.
- R7: With saturation off and a destination narrower than the access, the result is the low destination-width bits.
- R8: With saturation off and a destination wider than the access, the value is zero-extended.
- R9: Signed saturation (`in_sat` = 1) sign-extends the access, then clamps it to the range from -2^(d-1) to 2^(d-1)-1 for destination width d. The result is shown as d-bit two's complement.
- R10: Unsigned saturation (`in_sat` = 2) zero-extends the access, then clamps it to the range 0 to 2^d-1.
- R11: `in_sat` = 3 behaves exactly like saturation off (`in_sat` = 0).
- R12: Output bits at and above the destination width are always 0 (right-aligned result).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_raw | input | 64 | Raw word from memory, access in the low bytes |
| in_opw | input | 2 | Access size code |
| in_rev | input | 1 | Byte-reverse load flavour |
| in_le | input | 1 | Machine runs little-endian |
| in_dstw | input | 2 | Destination element size code |
| in_sat | input | 2 | Saturation: 0 off, 1 signed, 2 unsigned, 3 off |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Shaped result, right-aligned |

## Verification
The assertions assume that every control input is a known value whenever `in_valid` is high. They also assume the raw word and the control inputs are steady across the capturing edge. The bench meets both conditions by changing every input only on the falling clock edge. It drives full values for all fields, even in idle cycles, and only uses the four defined size codes. The check for the passthrough and single-byte cases also assumes that requests are separated by ordinary clocks, with no reset pulse in the middle. The directed tasks keep to this.

// File: rtl/load_shaper_pkg.sv
package load_shaper_pkg;

  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_B16 = 2'd1,
    SZ_B32 = 2'd2,
    SZ_B64 = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    CLAMP_OFF  = 2'd0,
    CLAMP_SGN  = 2'd1,
    CLAMP_UNS  = 2'd2,
    CLAMP_RSVD = 2'd3
  } clamp_e;

  // bit count of a size code
  function automatic int unsigned size_bits(input logic [1:0] code);
    return 32'd8 << code;
  endfunction

  // byte count of a size code
  function automatic int unsigned size_bytes(input logic [1:0] code);
    return 32'd1 << code;
  endfunction

endpackage

// File: rtl/load_shaper_swap.sv
// Selects the access bytes and optionally mirrors them inside the access.
module load_shaper_swap
  import load_shaper_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [1:0]        size,
  input  logic              mirror,
  output logic [DATA_W-1:0] shaped
);

  localparam int unsigned NBYTES = DATA_W / 8;

  always_comb begin
    int unsigned nb;
    nb = size_bytes(size);
    shaped = '0;
    for (int unsigned k = 0; k < NBYTES; k++) begin
      if (k < nb) begin
        if (mirror) begin
          shaped[8*k +: 8] = raw[8*(nb-1-k) +: 8];
        end else begin
          shaped[8*k +: 8] = raw[8*k +: 8];
        end
      end
    end
  end

endmodule

// File: rtl/load_shaper_widen.sv
// Widens the access into an intermediate one bit wider than the data path.
module load_shaper_widen
  import load_shaper_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] val,
  input  logic [1:0]        size,
  input  logic              sign_en,
  output logic [DATA_W:0]   wide
);

  always_comb begin
    int unsigned nbits;
    logic        fill;
    nbits = size_bits(size);
    fill  = sign_en & val[nbits-1];
    for (int unsigned k = 0; k <= DATA_W; k++) begin
      if (k < nbits) begin
        wide[k] = val[k];
      end else begin
        wide[k] = fill;
      end
    end
  end

endmodule

// File: rtl/load_shaper_clamp.sv
// Cuts or clamps the widened value to the destination element size.
module load_shaper_clamp
  import load_shaper_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W:0]   wide,
  input  logic [1:0]        dsize,
  input  logic [1:0]        mode,
  output logic [DATA_W-1:0] res
);

  localparam logic [DATA_W:0] ONE = {{DATA_W{1'b0}}, 1'b1};

  logic [DATA_W:0] umax;
  logic [DATA_W:0] smax;
  logic [DATA_W:0] smin;
  logic [DATA_W:0] picked;

  always_comb begin
    int unsigned db;
    db   = size_bits(dsize);
    umax = (ONE << db) - ONE;
    smax = (ONE << (db - 1)) - ONE;
    smin = ~smax;
  end

  always_comb begin
    picked = wide;
    unique case (clamp_e'(mode))
      CLAMP_SGN: begin
        if ($signed(wide) > $signed(smax)) begin
          picked = smax;
        end else if ($signed(wide) < $signed(smin)) begin
          picked = smin;
        end
      end
      CLAMP_UNS: begin
        if (wide > umax) begin
          picked = umax;
        end
      end
      default: picked = wide;
    endcase
    res = picked[DATA_W-1:0] & umax[DATA_W-1:0];
  end

endmodule

// File: rtl/load_shaper.sv
module load_shaper
  import load_shaper_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [63:0]       in_raw,
  input  logic [1:0]        in_opw,
  input  logic              in_rev,
  input  logic              in_le,
  input  logic [1:0]        in_dstw,
  input  logic [1:0]        in_sat,
  output logic              out_valid,
  output logic [63:0]       out_data
);

  logic [DATA_W-1:0] raw_w;
  logic [DATA_W-1:0] ordered;
  logic [DATA_W:0]   widened;
  logic [DATA_W-1:0] fitted;
  logic              mirror;
  logic              sign_en;

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              dat_en;

  assign raw_w   = DATA_W'(in_raw);
  assign mirror  = ~(in_rev ^ in_le);
  assign sign_en = (clamp_e'(in_sat) == CLAMP_SGN);

  load_shaper_swap #(.DATA_W(DATA_W)) u_swap (
    .raw    (raw_w),
    .size   (in_opw),
    .mirror (mirror),
    .shaped (ordered)
  );

  load_shaper_widen #(.DATA_W(DATA_W)) u_widen (
    .val     (ordered),
    .size    (in_opw),
    .sign_en (sign_en),
    .wide    (widened)
  );

  load_shaper_clamp #(.DATA_W(DATA_W)) u_clamp (
    .wide  (widened),
    .dsize (in_dstw),
    .mode  (in_sat),
    .res   (fitted)
  );

  // next state
  always_comb begin
    dat_en = in_valid;
    vld_d  = in_valid;
    dat_d  = dat_en ? fitted : dat_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = 64'(dat_q);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R3
  straight_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_opw == 2'd3 && in_dstw == 2'd3 && (in_rev != in_le)
     && (in_sat == 2'd0 || in_sat == 2'd3))
    |=> out_data == $past(in_raw));

  // R4
  single_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_opw == 2'd0 && in_dstw == 2'd0)
    |=> out_data == {56'd0, $past(in_raw[7:0])});

endmodule

// File: tb/load_shaper_test.sv
`timescale 1ns/1ps
module load_shaper_test;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_raw;
  logic [1:0]  in_opw;
  logic        in_rev;
  logic        in_le;
  logic [1:0]  in_dstw;
  logic [1:0]  in_sat;
  logic        out_valid;
  logic [63:0] out_data;

  int errs   = 0;
  int checks = 0;
  bit done   = 0;

  load_shaper uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_raw    (in_raw),
    .in_opw    (in_opw),
    .in_rev    (in_rev),
    .in_le     (in_le),
    .in_dstw   (in_dstw),
    .in_sat    (in_sat),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [63:0] PAT = 64'h0123_4567_89AB_CDEF;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request at a falling edge, check its result one cycle later
  task automatic run_one(input string req, input logic [63:0] raw, input logic [1:0] opw,
                         input logic rev, input logic le, input logic [1:0] dstw,
                         input logic [1:0] sat, input logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_raw = raw; in_opw = opw; in_rev = rev;
    in_le = le; in_dstw = dstw; in_sat = sat;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    check(req, out_data, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_raw = PAT; in_opw = 2'd3;
    in_rev = 1'b0; in_le = 1'b1; in_dstw = 2'd3; in_sat = 2'd0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 data in reset", out_data, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", {63'd0, out_valid}, 64'd0);
    check("R1 data after reset", out_data, 64'd0);
  endtask

  task automatic t_swap_decision;
    run_one("R3 rev0 le1 keep", PAT, 2'd3, 1'b0, 1'b1, 2'd3, 2'd0, PAT);
    run_one("R3 rev1 le0 keep", PAT, 2'd3, 1'b1, 1'b0, 2'd3, 2'd0, PAT);
    run_one("R3 rev0 le0 swap", PAT, 2'd3, 1'b0, 1'b0, 2'd3, 2'd0, 64'hEFCD_AB89_6745_2301);
    run_one("R3 rev1 le1 swap", PAT, 2'd3, 1'b1, 1'b1, 2'd3, 2'd0, 64'hEFCD_AB89_6745_2301);
  endtask

  task automatic t_width_window;
    run_one("R4 swap 32", PAT, 2'd2, 1'b1, 1'b1, 2'd3, 2'd0, 64'h0000_0000_EFCD_AB89);
    run_one("R4 swap 16", PAT, 2'd1, 1'b0, 1'b0, 2'd3, 2'd0, 64'h0000_0000_0000_EFCD);
    run_one("R4 swap 8", PAT, 2'd0, 1'b0, 1'b0, 2'd3, 2'd0, 64'h0000_0000_0000_00EF);
    run_one("R5 R6 keep 16", PAT, 2'd1, 1'b0, 1'b1, 2'd3, 2'd0, 64'h0000_0000_0000_CDEF);
    run_one("R5 R6 keep 32", PAT, 2'd2, 1'b0, 1'b1, 2'd3, 2'd0, 64'h0000_0000_89AB_CDEF);
  endtask

  task automatic t_plain_resize;
    run_one("R7 cut 64 to 16", PAT, 2'd3, 1'b0, 1'b1, 2'd1, 2'd0, 64'h0000_0000_0000_CDEF);
    run_one("R7 cut 64 to 8", PAT, 2'd3, 1'b0, 1'b1, 2'd0, 2'd0, 64'h0000_0000_0000_00EF);
    run_one("R8 zero ext 8 to 32", 64'hFFFF_FFFF_FFFF_FF80, 2'd0, 1'b0, 1'b1, 2'd2, 2'd0,
            64'h0000_0000_0000_0080);
  endtask

  task automatic t_signed_sat;
    run_one("R9 low clamp", 64'h0000_0000_0000_8000, 2'd1, 1'b0, 1'b1, 2'd0, 2'd1, 64'h80);
    run_one("R9 high clamp", 64'h0000_0000_0000_7FFF, 2'd1, 1'b0, 1'b1, 2'd0, 2'd1, 64'h7F);
    run_one("R9 in range", 64'h0000_0000_0000_0042, 2'd1, 1'b0, 1'b1, 2'd0, 2'd1, 64'h42);
    run_one("R9 R12 minus one widen", 64'hAAAA_AAAA_AAAA_AAFF, 2'd0, 1'b0, 1'b1, 2'd2, 2'd1,
            64'h0000_0000_FFFF_FFFF);
    run_one("R9 exact min", 64'h0000_0000_FFFF_FF80, 2'd2, 1'b0, 1'b1, 2'd0, 2'd1, 64'h80);
    run_one("R9 below min", 64'h0000_0000_FFFF_FF7F, 2'd2, 1'b0, 1'b1, 2'd0, 2'd1, 64'h80);
    run_one("R9 above max", 64'h0000_0000_0000_0080, 2'd2, 1'b0, 1'b1, 2'd0, 2'd1, 64'h7F);
    run_one("R9 full 64 neg", 64'h8000_0000_0000_0000, 2'd3, 1'b0, 1'b1, 2'd3, 2'd1,
            64'h8000_0000_0000_0000);
    run_one("R9 R3 swapped then clamp", 64'hDEAD_BEEF_0000_0080, 2'd1, 1'b0, 1'b0, 2'd0, 2'd1,
            64'h80);
  endtask

  task automatic t_unsigned_sat;
    run_one("R10 clamp top", 64'h0000_0000_0000_0100, 2'd1, 1'b0, 1'b1, 2'd0, 2'd2, 64'hFF);
    run_one("R10 at max", 64'h0000_0000_0000_00FF, 2'd1, 1'b0, 1'b1, 2'd0, 2'd2, 64'hFF);
    run_one("R10 in range", 64'h0000_0000_0000_00FE, 2'd1, 1'b0, 1'b1, 2'd0, 2'd2, 64'hFE);
    run_one("R10 64 to 32", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 1'b1, 2'd2, 2'd2,
            64'h0000_0000_FFFF_FFFF);
    run_one("R10 no sign ext", 64'h0000_0000_0000_0080, 2'd0, 1'b0, 1'b1, 2'd1, 2'd2, 64'h80);
  endtask

  task automatic t_sat_encoding;
    run_one("R11 code3 cuts", 64'h0000_0000_0000_0100, 2'd1, 1'b0, 1'b1, 2'd0, 2'd3, 64'h00);
    run_one("R11 code3 zero ext", 64'h0000_0000_0000_0080, 2'd0, 1'b0, 1'b1, 2'd1, 2'd3, 64'h80);
    run_one("R12 upper clear", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 1'b1, 2'd1, 2'd0, 64'hFFFF);
  endtask

  task automatic t_pipeline;
    @(negedge clk);
    in_valid = 1'b1; in_raw = PAT; in_opw = 2'd3; in_rev = 1'b0; in_le = 1'b1;
    in_dstw = 2'd3; in_sat = 2'd0;
    @(negedge clk);
    check("R2 first of pair", out_data, PAT);
    in_raw = 64'h1111_2222_3333_4444;
    @(negedge clk);
    check("R2 second of pair valid", {63'd0, out_valid}, 64'd1);
    check("R2 second of pair", out_data, 64'h1111_2222_3333_4444);
    in_valid = 1'b0; in_raw = 64'h5555_5555_5555_5555;
    @(negedge clk);
    check("R2 idle valid low", {63'd0, out_valid}, 64'd0);
    check("R2 idle holds data", out_data, 64'h1111_2222_3333_4444);
    @(negedge clk);
    check("R2 still held", out_data, 64'h1111_2222_3333_4444);
  endtask

  initial begin
    t_reset();
    t_swap_decision();
    t_width_window();
    t_plain_resize();
    t_signed_sat();
    t_unsigned_sat();
    t_sat_encoding();
    t_pipeline();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule